// File: doc/BRIEF.md
# Locked Configuration Store with User Signature

This block keeps the configuration image of a programmable logic array: a pattern of `PAT_BITS` bits (256 by default) and a separate user signature of `SIG_BITS` bits (64 by default). The user signature is free-form data, such as an ID code or a revision number. A one-bit lock comes with the image. Both parts are held as 16-bit words in one word-wide memory. The pattern occupies word addresses 0 to 15. The signature follows at addresses 16 to 19.

A single command port carries four operations. Each operation has an encoding in `cmd_op`:

| Encoding | Operation |
|---|---|
| 0 | program |
| 1 | read a pattern word |
| 2 | read a signature word |
| 3 | read the checksum |

A program command first wipes every word and the lock to zero. It then pulls the new image one word per cycle from an external source through `fetch_idx`/`fetch_data`. When the last word lands, it applies the lock value given with the command.

While the lock is set, pattern words cannot be read back. Signature words always can. The only way to clear the lock is to program again.

The checksum is the 16-bit wrapping sum of every stored word, signature words included. It is formed while the image is written, so it is fresh when the program completes.

Top module: `cfgstore_top`

## Requirements
- R1: A program command accepted while idle raises `busy` for exactly 2×N_WORDS cycles (20 erase cycles, then 20 write cycles). `fetch_en` is high only in the second half, with `fetch_idx` counting 0,1,…,N_WORDS−1 one step per cycle. `fetch_data` is taken in the same cycle as the index it belongs to.
- R2: When the lock is clear, a pattern read (op 1) at word address A has two cycles of latency. It yields one `rd_valid` cycle carrying the word last loaded at index A, with `read_denied` low.
- R3: When the lock is set, a pattern read yields `rd_valid` with `rd_data` equal to zero and `read_denied` high for that single cycle only.
- R4: A signature read (op 2) with address A returns the word loaded at index 16 + (A mod 4), whether or not the lock is set, and never raises `read_denied`.
- R5: A checksum read (op 3) returns the 16-bit modular sum of all 20 stored words. Reprogramming with only a signature word altered changes the returned value accordingly.
- R6: The lock takes the `cmd_lock` value sampled with the accepted program command. No read command changes it. A set lock is cleared only by a later program with `cmd_lock` = 0.
- R7: Any command presented while `busy` is high is ignored: no read result, no restart and no change of the lock or of the busy length. `cmd_err` pulses high for one cycle after it.
- R8: After reset `busy`, `fetch_en`, `cmd_err`, `rd_valid` and `read_denied` are low, and a checksum read returns zero.
- R9: A command presented in the first cycle after `busy` falls is accepted. It observes the newly loaded words, lock and checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 program, 1 pattern read, 2 signature read, 3 checksum read |
| cmd_addr | input | 4 | Word address for reads |
| cmd_lock | input | 1 | Lock value to apply at the end of a program |
| busy | output | 1 | Erase/write sequence in progress |
| cmd_err | output | 1 | One-cycle pulse: a command arrived while busy |
| fetch_en | output | 1 | Write phase active; `fetch_data` is consumed this cycle |
| fetch_idx | output | 5 | Index of the image word wanted this cycle |
| fetch_data | input | 16 | Image word for `fetch_idx` |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result |
| read_denied | output | 1 | Pattern read refused because the lock is set |

## Verification
Two functions can land in the same cycle.

The first pair is the end of a program and a fresh command. The bench issues a read in the very cycle after `busy` falls. It expects the new word, the new lock and the new checksum, never the values from before the program.

The second pair is the program sequence and an intruding command. Partway through a sequence the bench presents a program command with the opposite lock value. It then checks four things: `cmd_err` pulses once, the busy length is unchanged, no read result appears, and the lock after completion follows the original command.

// File: rtl/cfgstore_pkg.sv
`timescale 1ns/1ps
package cfgstore_pkg;
  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_RD_PAT  = 2'd1,
    OP_RD_SIG  = 2'd2,
    OP_RD_SUM  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/cfg_word_ram.sv
`timescale 1ns/1ps
module cfg_word_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 20,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfg_prog_seq.sv
`timescale 1ns/1ps
module cfg_prog_seq
  import cfgstore_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 20,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_lock,
  input  logic [WORD_W-1:0] fetch_data,
  output logic              busy,
  output logic              fetch_en,
  output logic [IDX_W-1:0]  fetch_idx,
  output logic              we,
  output logic [IDX_W-1:0]  waddr,
  output logic [WORD_W-1:0] wdata,
  output logic              lock,
  output logic [WORD_W-1:0] checksum
);
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] acc;
  logic              lock_pend;
  logic              last;

  assign last = (idx == IDX_W'(N_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      acc       <= '0;
      lock_pend <= 1'b0;
      lock      <= 1'b0;
      checksum  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase     <= PH_ERASE;
            idx       <= '0;
            acc       <= '0;
            lock_pend <= start_lock;
            lock      <= 1'b0;
            checksum  <= '0;
          end
        end
        PH_ERASE: begin
          if (last) begin
            phase <= PH_WRITE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_WRITE: begin
          acc <= acc + fetch_data;
          if (last) begin
            phase    <= PH_IDLE;
            idx      <= '0;
            lock     <= lock_pend;
            checksum <= acc + fetch_data;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign fetch_en  = (phase == PH_WRITE);
  assign fetch_idx = idx;
  assign we        = busy;
  assign waddr     = idx;
  assign wdata     = fetch_en ? fetch_data : '0;

  p_fetch_busy_r1: assert property (@(posedge clk) disable iff (rst)
    fetch_en |-> busy);
  p_fetch_step_r1: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && $past(fetch_en)) |-> (fetch_idx == $past(fetch_idx) + 1'b1));
  p_lock_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(lock));
  p_sum_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(checksum));
endmodule

// File: rtl/cfg_read_port.sv
`timescale 1ns/1ps
module cfg_read_port
  import cfgstore_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  op_e               op,
  input  logic              lock,
  input  logic [WORD_W-1:0] ram_q,
  input  logic [WORD_W-1:0] checksum,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              read_denied
);
  logic v1;
  op_e  op1;
  logic lk1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1  <= 1'b0;
      op1 <= OP_RD_SUM;
      lk1 <= 1'b0;
    end else begin
      v1  <= go;
      op1 <= op;
      lk1 <= lock;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      read_denied <= 1'b0;
    end else begin
      rd_valid    <= v1;
      read_denied <= v1 && (op1 == OP_RD_PAT) && lk1;
      if (v1) begin
        unique case (op1)
          OP_RD_PAT: rd_data <= lk1 ? '0 : ram_q;
          OP_RD_SIG: rd_data <= ram_q;
          OP_RD_SUM: rd_data <= checksum;
          default:   rd_data <= '0;
        endcase
      end else begin
        rd_data <= '0;
      end
    end
  end

  p_denied_valid_r3: assert property (@(posedge clk) disable iff (rst)
    read_denied |-> rd_valid);
  p_denied_zero_r3: assert property (@(posedge clk) disable iff (rst)
    read_denied |-> (rd_data == '0));
  p_denied_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    read_denied |=> !read_denied || $past(v1));
endmodule

// File: rtl/cfgstore_top.sv
`timescale 1ns/1ps
module cfgstore_top
  import cfgstore_pkg::*;
#(
  parameter  int PAT_BITS  = 256,
  parameter  int SIG_BITS  = 64,
  parameter  int WORD_W    = 16,
  localparam int PAT_WORDS = PAT_BITS / WORD_W,
  localparam int SIG_WORDS = SIG_BITS / WORD_W,
  localparam int N_WORDS   = PAT_WORDS + SIG_WORDS,
  localparam int IDX_W     = $clog2(N_WORDS),
  localparam int ADDR_W    = $clog2(PAT_WORDS),
  localparam int SIG_AW    = $clog2(SIG_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_lock,
  output logic              busy,
  output logic              cmd_err,
  output logic              fetch_en,
  output logic [IDX_W-1:0]  fetch_idx,
  input  logic [WORD_W-1:0] fetch_data,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              read_denied
);
  op_e               op;
  logic              accept, prog_go, rd_go;
  logic              we;
  logic [IDX_W-1:0]  waddr, raddr;
  logic [WORD_W-1:0] wdata, ram_q, checksum;
  logic              lock;

  assign op      = op_e'(cmd_op);
  assign accept  = cmd_valid && !busy;
  assign prog_go = accept && (op == OP_PROGRAM);
  assign rd_go   = accept && (op != OP_PROGRAM);

  always_comb begin
    if (op == OP_RD_SIG)
      raddr = IDX_W'(PAT_WORDS) + IDX_W'(cmd_addr[SIG_AW-1:0]);
    else
      raddr = IDX_W'(cmd_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_err <= 1'b0;
    else     cmd_err <= cmd_valid && busy;
  end

  cfg_prog_seq #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(prog_go), .start_lock(cmd_lock),
    .fetch_data(fetch_data), .busy(busy), .fetch_en(fetch_en),
    .fetch_idx(fetch_idx), .we(we), .waddr(waddr), .wdata(wdata),
    .lock(lock), .checksum(checksum)
  );

  cfg_word_ram #(.W(WORD_W), .DEPTH(N_WORDS), .AW(IDX_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(ram_q)
  );

  cfg_read_port #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .go(rd_go), .op(op), .lock(lock),
    .ram_q(ram_q), .checksum(checksum),
    .rd_valid(rd_valid), .rd_data(rd_data), .read_denied(read_denied)
  );

  p_err_busy_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(busy));
  p_no_read_busy_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(busy, 2));
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_err && !busy) |=> !cmd_err);
endmodule

// File: tb/sim_cfgstore_top.sv
`timescale 1ns/1ps
module sim_cfgstore_top;
  localparam int NW = 20;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [3:0]  cmd_addr = 4'd0;
  logic        cmd_lock = 1'b0;
  logic        busy, cmd_err, fetch_en, rd_valid, read_denied;
  logic [4:0]  fetch_idx;
  logic [15:0] fetch_data, rd_data;

  logic [15:0] img     [NW];
  logic [15:0] exp_mem [NW];
  logic        exp_lock = 1'b0;
  logic [15:0] exp_sum  = 16'd0;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign fetch_data = (fetch_idx < 5'(NW)) ? img[fetch_idx] : 16'd0;

  cfgstore_top u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_lock(cmd_lock), .busy(busy), .cmd_err(cmd_err),
    .fetch_en(fetch_en), .fetch_idx(fetch_idx), .fetch_data(fetch_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .read_denied(read_denied)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_img();
    logic [15:0] s = 16'd0;
    for (int i = 0; i < NW; i++) s = s + img[i];
    return s;
  endfunction

  function automatic logic [15:0] exp_read(input int op, input int a);
    if (op == 1) return exp_lock ? 16'd0 : exp_mem[a];
    if (op == 2) return exp_mem[NP + (a % 4)];
    return exp_sum;
  endfunction

  task automatic rand_img();
    for (int i = 0; i < NW; i++) img[i] = 16'($urandom);
  endtask

  // Called and returns at a negedge
  task automatic do_program(input bit lk, input bit inject);
    int cyc = 0;
    int fcnt = 0;
    bit early_fetch = 0;
    bit seen_rd = 0;
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_lock = lk;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R1 busy after accept", 32'(busy), 1);
    while (busy && cyc < 1000) begin
      if (fetch_en) begin
        if (cyc < NW) early_fetch = 1;
        check(fetch_idx == 5'(fcnt), "R1 fetch order", 32'(fetch_idx), 32'(fcnt));
        fcnt++;
      end
      if (rd_valid) seen_rd = 1;
      if (inject && cyc == 5) begin
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_lock = !lk;
      end
      if (inject && cyc == 6) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = 4'd3;
        check(cmd_err == 1'b1, "R7 err pulse", 32'(cmd_err), 1);
      end
      if (inject && cyc == 7) cmd_valid = 1'b0;
      if (inject && cyc == 9)
        check(cmd_err == 1'b0, "R7 err ends", 32'(cmd_err), 0);
      cyc++;
      @(negedge clk);
    end
    check(cyc == 2*NW, "R1 busy length", 32'(cyc), 32'(2*NW));
    check(fcnt == NW, "R1 fetch count", 32'(fcnt), 32'(NW));
    check(!early_fetch, "R1 fetch only in write half", 32'(early_fetch), 0);
    if (inject) check(!seen_rd, "R7 no read while busy", 32'(seen_rd), 0);
    for (int i = 0; i < NW; i++) exp_mem[i] = img[i];
    exp_lock = lk;
    exp_sum  = sum_img();
  endtask

  // Called and returns at a negedge
  task automatic do_read(input int op, input int a, input string req);
    logic [15:0] e;
    e = exp_read(op, a);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = 4'(a);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b1, {req, " valid"}, 32'(rd_valid), 1);
    check(rd_data == e, {req, " data"}, 32'(rd_data), 32'(e));
    check(read_denied == (op == 1 && exp_lock), {req, " denied"},
          32'(read_denied), 32'(op == 1 && exp_lock));
    @(negedge clk);
    check(!rd_valid && !read_denied, {req, " R3 single-cycle result"},
          32'({rd_valid, read_denied}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) img[i] = 16'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check({busy, fetch_en, cmd_err, rd_valid, read_denied} == 5'd0,
          "R8 reset outputs", 32'({busy, fetch_en, cmd_err, rd_valid, read_denied}), 0);
    do_read(3, 0, "R8 checksum after reset");

    // Unlocked program, first-idle-cycle read (R9), full readback
    rand_img();
    do_program(1'b0, 1'b0);
    do_read(1, 7, "R9 read right after busy falls");
    for (int a = 0; a < NP; a++) do_read(1, a, "R2 pattern read");
    for (int a = 0; a < 4; a++) do_read(2, a + 4, "R4 signature read");
    do_read(3, 0, "R5 checksum");

    // Locked program: pattern denied, signature always readable
    rand_img();
    do_program(1'b1, 1'b0);
    do_read(1, 0, "R9 locked read right after busy falls");
    for (int a = 0; a < NP; a += 5) do_read(1, a, "R3 locked pattern read");
    for (int a = 0; a < 4; a++) do_read(2, a, "R4 signature under lock");
    do_read(1, 15, "R6 lock kept after reads");
    do_read(3, 0, "R5 checksum under lock");

    // Only one signature word changes: checksum must move (R5)
    begin
      logic [15:0] old_sum;
      old_sum = exp_sum;
      img[NP + 2] = img[NP + 2] + 16'h0101;
      do_program(1'b1, 1'b0);
      check(exp_sum != old_sum, "R5 model sum moved", 32'(exp_sum), 32'(old_sum));
      do_read(3, 0, "R5 checksum after signature change");
    end

    // Reprogram unlocked clears lock (R6)
    do_program(1'b0, 1'b0);
    do_read(1, 4, "R6 unlocked by reprogram");

    // Intruding program with opposite lock during busy (R7)
    rand_img();
    do_program(1'b0, 1'b1);
    do_read(1, 3, "R7 lock follows first command");
    do_read(3, 0, "R7 checksum after intrusion");

    // Wrap corner: all ones
    for (int i = 0; i < NW; i++) img[i] = 16'hFFFF;
    do_program(1'b0, 1'b0);
    do_read(3, 0, "R5 checksum wrap all ones");

    // Random mix
    for (int k = 0; k < 3; k++) begin
      rand_img();
      do_program(1'($urandom), 1'($urandom));
      for (int j = 0; j < 10; j++)
        do_read(1 + int'($urandom % 3), int'($urandom % 16), "R2 R4 R5 random read");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule